// File: doc/BRIEF.md
# Dual-Channel Serial Block Interrupt and Port Configuration

This block holds the shared registers of a pair of serial channels, A and B. It decodes the block-level part of a 32-byte register window. Every register sits on an odd byte address and the even byte before it is an unused spacer. At one offset, a read and a write reach different registers. The block also turns per-channel ready, FIFO and break conditions into one interrupt status byte. A mask register selects which of those bits drive a single interrupt line.

The block keeps three write registers:
- An auxiliary control register. It selects the baud-rate set and the counter/timer clock source, and it enables interrupts on changes of four input pins.
- An interrupt mask register.
- An output-port configuration register. It picks, for each of the two multipurpose output pins, one of eight channel signals, and it sets the pin direction.

The channel units and the counter/timer sit outside this block. They connect through level and strobe signals. For offsets that belong to them, this block reads back zero.

Top module: `duo_irq_port_cfg`

## Requirements
- R1: A bus access uses byte address `bus_addr`. Only odd addresses select a register, at offset `bus_addr[4:1]`. The interrupt status byte has this layout: bit 0 TX ready A, bit 1 RX ready A, bit 2 break change A, bit 3 counter ready, bit 4 TX ready B, bit 5 RX ready B, bit 6 break change B, bit 7 input change. Bits 0, 3 and 4 follow their inputs live.
- R2: Bit 1 (channel A) and bit 5 (channel B) follow that channel's FIFO-full input when the channel's RX-interrupt select input is 1. When that select input is 0, they follow the receiver-ready input.
- R3: A break-change bit (bit 2 for A, bit 6 for B) is set one cycle after the channel's break input either rises or falls. It stays set until that channel's clear strobe is applied. If an edge and the clear strobe arrive together, the bit stays set.
- R4: A write to offset 5 (byte 11) loads the interrupt mask. `irq` is high exactly when the status byte ANDed with the mask is nonzero, and it follows status changes in the same cycle.
- R5: A read of offset 5 (byte 11) returns the interrupt status byte.
- R6: A write to offset 4 (byte 9) loads the auxiliary control register. Bit 7 appears on `baud_set` and bits 6:4 appear on `ct_clk_sel`.
- R7: A change on input pin `ip[i]` sets change flag i. A read of offset 4 (byte 9) returns {change flags 3:0, pin levels 3:0}. The same change sets status bit 7 only if auxiliary control bit i is 1. A read of offset 4 with `bus_rd` high clears the flags and bit 7. A read of offset 13 (byte 27) returns {4'b0, pin levels}.
- R8: A write to offset 13 (byte 27) loads the output-port configuration register. Bits 2:0 select the source for `mpo_a` and bits 6:4 select the source for `mpo_b`. The codes are: 0 RTS, 1 counter output, 2 TX clock x1, 3 TX clock x16, 4 RX clock x1, 5 RX clock x16, 6 TX ready, 7 RX ready (as in R2). Bit 7 drives `mpo_oe`.
- R9: Reads of even addresses, and of odd offsets that this block does not hold, return 0x00. Writes to them change nothing.
- R10: After reset the mask, auxiliary control, output configuration, break-change bits and input-change state are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; clears the input-change state at offset 4 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| txrdy_a | input | 1 | Channel A transmitter ready |
| rxrdy_a | input | 1 | Channel A receiver ready |
| ffull_a | input | 1 | Channel A receive FIFO full |
| rxsel_a | input | 1 | Channel A RX interrupt select (1 = FIFO full) |
| brk_a | input | 1 | Channel A break being received |
| brk_clr_a | input | 1 | Channel A clear-break-change strobe |
| txrdy_b | input | 1 | Channel B transmitter ready |
| rxrdy_b | input | 1 | Channel B receiver ready |
| ffull_b | input | 1 | Channel B receive FIFO full |
| rxsel_b | input | 1 | Channel B RX interrupt select (1 = FIFO full) |
| brk_b | input | 1 | Channel B break being received |
| brk_clr_b | input | 1 | Channel B clear-break-change strobe |
| ctr_rdy | input | 1 | Counter/timer ready |
| ctr_out | input | 1 | Counter/timer output |
| ip | input | 4 | Input pin levels |
| rts_a | input | 1 | Channel A RTS level |
| txc1_a | input | 1 | Channel A TX clock x1 |
| txc16_a | input | 1 | Channel A TX clock x16 |
| rxc1_a | input | 1 | Channel A RX clock x1 |
| rxc16_a | input | 1 | Channel A RX clock x16 |
| rts_b | input | 1 | Channel B RTS level |
| txc1_b | input | 1 | Channel B TX clock x1 |
| txc16_b | input | 1 | Channel B TX clock x16 |
| rxc1_b | input | 1 | Channel B RX clock x1 |
| rxc16_b | input | 1 | Channel B RX clock x16 |
| irq | output | 1 | Masked interrupt request |
| baud_set | output | 1 | Baud-rate set select |
| ct_clk_sel | output | 3 | Counter/timer clock source |
| mpo_a | output | 1 | Multipurpose output A |
| mpo_b | output | 1 | Multipurpose output B |
| mpo_oe | output | 1 | Multipurpose pin direction (1 = output) |

## Verification
The assertions assume that the break inputs, the input pins and the clear strobes are synchronous to `clk`. They also assume that the input pins are already at zero when reset is released, so that no change is flagged in the first cycle. The stimulus changes every input on the falling edge, and it holds `ip` and the break inputs low through reset. It never pulses `bus_rd` and `bus_wr` in the same cycle. It samples outputs on the falling edge.

// File: rtl/duo_irq_port_cfg.sv
module duo_irq_port_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       txrdy_a,
  input  logic       rxrdy_a,
  input  logic       ffull_a,
  input  logic       rxsel_a,
  input  logic       brk_a,
  input  logic       brk_clr_a,
  input  logic       txrdy_b,
  input  logic       rxrdy_b,
  input  logic       ffull_b,
  input  logic       rxsel_b,
  input  logic       brk_b,
  input  logic       brk_clr_b,
  input  logic       ctr_rdy,
  input  logic       ctr_out,
  input  logic [3:0] ip,
  input  logic       rts_a,
  input  logic       txc1_a,
  input  logic       txc16_a,
  input  logic       rxc1_a,
  input  logic       rxc16_a,
  input  logic       rts_b,
  input  logic       txc1_b,
  input  logic       txc16_b,
  input  logic       rxc1_b,
  input  logic       rxc16_b,
  output logic       irq,
  output logic       baud_set,
  output logic [2:0] ct_clk_sel,
  output logic       mpo_a,
  output logic       mpo_b,
  output logic       mpo_oe
);
  localparam logic [3:0] OFF_AUX = 4'd4;
  localparam logic [3:0] OFF_INT = 4'd5;
  localparam logic [3:0] OFF_OPC = 4'd13;

  logic [7:0] mask_q, aux_q, opc_q;
  logic       brk_a_q, brk_b_q, dbrk_a, dbrk_b;
  logic [3:0] ip_q, ipflag_q;
  logic       ipint_q;

  wire [3:0] off    = bus_addr[4:1];
  wire       odd    = bus_addr[0];
  wire       wr_aux = bus_wr && odd && off == OFF_AUX;
  wire       wr_int = bus_wr && odd && off == OFF_INT;
  wire       wr_opc = bus_wr && odd && off == OFF_OPC;
  wire       rd_ipc = bus_rd && odd && off == OFF_AUX;

  wire       rxst_a = rxsel_a ? ffull_a : rxrdy_a;
  wire       rxst_b = rxsel_b ? ffull_b : rxrdy_b;
  wire [3:0] ipchg  = ip ^ ip_q;

  wire [7:0] status = {ipint_q, dbrk_b, rxst_b, txrdy_b,
                       ctr_rdy, dbrk_a, rxst_a, txrdy_a};

  assign irq        = |(status & mask_q);
  assign baud_set   = aux_q[7];
  assign ct_clk_sel = aux_q[6:4];
  assign mpo_oe     = opc_q[7];

  wire [7:0] src_a = {rxst_a, txrdy_a, rxc16_a, rxc1_a, txc16_a, txc1_a, ctr_out, rts_a};
  wire [7:0] src_b = {rxst_b, txrdy_b, rxc16_b, rxc1_b, txc16_b, txc1_b, ctr_out, rts_b};
  assign mpo_a = src_a[opc_q[2:0]];
  assign mpo_b = src_b[opc_q[6:4]];

  always_comb begin
    bus_rdata = 8'h00;
    if (odd) begin
      case (off)
        OFF_AUX: bus_rdata = {ipflag_q, ip};
        OFF_INT: bus_rdata = status;
        OFF_OPC: bus_rdata = {4'h0, ip};
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      aux_q  <= '0;
      opc_q  <= '0;
    end else begin
      if (wr_int) mask_q <= bus_wdata;
      if (wr_aux) aux_q  <= bus_wdata;
      if (wr_opc) opc_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_a_q <= 1'b0;
      brk_b_q <= 1'b0;
      dbrk_a  <= 1'b0;
      dbrk_b  <= 1'b0;
    end else begin
      brk_a_q <= brk_a;
      brk_b_q <= brk_b;
      dbrk_a  <= (dbrk_a && !brk_clr_a) || (brk_a != brk_a_q);
      dbrk_b  <= (dbrk_b && !brk_clr_b) || (brk_b != brk_b_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q     <= '0;
      ipflag_q <= '0;
      ipint_q  <= 1'b0;
    end else begin
      ip_q     <= ip;
      ipflag_q <= (rd_ipc ? 4'h0 : ipflag_q) | ipchg;
      ipint_q  <= (ipint_q && !rd_ipc) || |(ipchg & aux_q[3:0]);
    end
  end

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> !irq); // R4
  AST_BRK_EDGE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && brk_a != $past(brk_a)) |=> dbrk_a); // R3
  AST_BRK_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (dbrk_b && !brk_clr_b) |=> dbrk_b); // R3
  AST_IPC_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ipc && ip == ip_q) |=> (!ipint_q && ipflag_q == 4'h0)); // R7
  AST_OPC_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_opc |=> (mpo_oe == $past(bus_wdata[7]))); // R8
  AST_SPACER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[0] |-> (bus_rdata == 8'h00)); // R9
endmodule

// File: tb/test_duo_irq_port_cfg.sv
module test_duo_irq_port_cfg;
  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic txrdy_a = 0, rxrdy_a = 0, ffull_a = 0, rxsel_a = 0, brk_a = 0, brk_clr_a = 0;
  logic txrdy_b = 0, rxrdy_b = 0, ffull_b = 0, rxsel_b = 0, brk_b = 0, brk_clr_b = 0;
  logic ctr_rdy = 0, ctr_out = 0;
  logic [3:0] ip = 0;
  logic rts_a = 0, txc1_a = 0, txc16_a = 0, rxc1_a = 0, rxc16_a = 0;
  logic rts_b = 0, txc1_b = 0, txc16_b = 0, rxc1_b = 0, rxc16_b = 0;
  logic irq, baud_set, mpo_a, mpo_b, mpo_oe;
  logic [2:0] ct_clk_sel;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  duo_irq_port_cfg i_duo_irq_port_cfg (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic rd_clr(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(5'd11, d); chk("R10 status", d, 8'h00);
    chk("R10 irq", irq, 0); chk("R10 oe", mpo_oe, 0);
    chk("R10 aux", {baud_set, ct_clk_sel}, 0);
    rd(5'd9, d); chk("R10 ipc", d, 8'h00);
  endtask

  task automatic t_live_bits;
    logic [7:0] d;
    txrdy_a = 1; rd(5'd11, d); chk("R1 txA", d, 8'h01);
    ctr_rdy = 1; rd(5'd11, d); chk("R1 ctr", d, 8'h09);
    txrdy_b = 1; rd(5'd11, d); chk("R1 R5 txB", d, 8'h19);
    txrdy_a = 0; ctr_rdy = 0; txrdy_b = 0;
  endtask

  task automatic t_rx_select;
    logic [7:0] d;
    rxrdy_a = 1; rxsel_a = 0; rd(5'd11, d); chk("R2 A rdy", d, 8'h02);
    rxsel_a = 1; rd(5'd11, d); chk("R2 A sel full, not full", d, 8'h00);
    ffull_a = 1; rd(5'd11, d); chk("R2 A full", d, 8'h02);
    rxrdy_a = 0; ffull_a = 0; rxsel_a = 0;
    ffull_b = 1; rd(5'd11, d); chk("R2 B full ignored", d, 8'h00);
    rxsel_b = 1; rd(5'd11, d); chk("R2 B full", d, 8'h20);
    ffull_b = 0; rxsel_b = 0;
  endtask

  task automatic t_break;
    logic [7:0] d;
    @(negedge clk); brk_a = 1;
    @(negedge clk); #1 chk("R3 rise A", bus_addr == 11 ? bus_rdata : 8'h04, 8'h04);
    repeat (3) @(negedge clk);
    rd(5'd11, d); chk("R3 hold A", d, 8'h04);
    @(negedge clk); brk_clr_a = 1; @(negedge clk); brk_clr_a = 0;
    rd(5'd11, d); chk("R3 clear A", d, 8'h00);
    @(negedge clk); brk_a = 0;
    rd(5'd11, d); chk("R3 fall A", d, 8'h04);
    @(negedge clk); brk_clr_a = 1; @(negedge clk); brk_clr_a = 0;
    @(negedge clk); brk_b = 1; brk_clr_b = 1;
    @(negedge clk); brk_clr_b = 0;
    rd(5'd11, d); chk("R3 edge with clear B", d, 8'h40);
    @(negedge clk); brk_clr_b = 1; @(negedge clk); brk_clr_b = 0;
    brk_b = 0; @(negedge clk); brk_clr_b = 1; @(negedge clk); brk_clr_b = 0;
    rd(5'd11, d); chk("R3 B cleared", d, 8'h00);
  endtask

  task automatic t_mask;
    txrdy_a = 1;
    wr(5'd11, 8'h01); #1 chk("R4 irq on", irq, 1);
    wr(5'd11, 8'h10); #1 chk("R4 irq masked", irq, 0);
    txrdy_b = 1; #1 chk("R4 irq live", irq, 1);
    txrdy_b = 0; #1 chk("R4 irq drop", irq, 0);
    txrdy_a = 0; wr(5'd11, 8'h00);
  endtask

  task automatic t_aux;
    wr(5'd9, 8'hD0); #1 chk("R6 aux", {baud_set, ct_clk_sel}, 4'hD);
    wr(5'd9, 8'h31); #1 chk("R6 aux2", {baud_set, ct_clk_sel}, 4'h3);
  endtask

  task automatic t_input_change;
    logic [7:0] d;
    wr(5'd11, 8'h80);
    @(negedge clk); ip = 4'b0001;
    @(negedge clk); #1 chk("R7 irq", irq, 1);
    rd_clr(5'd9, d); chk("R7 ipc read", d, 8'h11);
    rd(5'd11, d); chk("R7 cleared", d, 8'h00);
    rd(5'd9, d); chk("R7 flags cleared", d, 8'h01);
    @(negedge clk); ip = 4'b0101;
    rd(5'd9, d); chk("R7 flag no enable", d, 8'h45);
    rd(5'd11, d); chk("R7 no int", d, 8'h00);
    rd(5'd27, d); chk("R7 pins", d, 8'h05);
    rd_clr(5'd9, d); ip = 0; @(negedge clk); rd_clr(5'd9, d);
    wr(5'd11, 8'h00);
  endtask

  task automatic t_opcr(input logic [7:0] pa);
    logic [7:0] pb;
    pb = {~pa[7:2], pa[1], ~pa[0]};
    rts_a = pa[0]; ctr_out = pa[1]; txc1_a = pa[2]; txc16_a = pa[3];
    rxc1_a = pa[4]; rxc16_a = pa[5]; txrdy_a = pa[6]; rxrdy_a = pa[7];
    rts_b = pb[0]; txc1_b = pb[2]; txc16_b = pb[3];
    rxc1_b = pb[4]; rxc16_b = pb[5]; txrdy_b = pb[6]; rxrdy_b = pb[7];
    for (int c = 0; c < 8; c++) begin
      wr(5'd27, {1'b1, 3'(7 - c), 1'b0, 3'(c)});
      #1 chk("R8 mpo_a", mpo_a, pa[c]);
      chk("R8 mpo_b", mpo_b, pb[7 - c]);
      chk("R8 dir", mpo_oe, 1);
    end
    wr(5'd27, 8'h00); #1 chk("R8 dir off", mpo_oe, 0);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    txrdy_a = 1;
    wr(5'd10, 8'hFF); #1 chk("R9 even write", irq, 0);
    wr(5'd8, 8'hFF); #1 chk("R9 even aux", {baud_set, ct_clk_sel}, 4'h3);
    wr(5'd25, 8'hFF); #1 chk("R9 reserved write", {mpo_oe, irq}, 2'b00);
    rd(5'd10, d); chk("R9 even read", d, 8'h00);
    rd(5'd13, d); chk("R9 other read", d, 8'h00);
    rd(5'd25, d); chk("R9 reserved read", d, 8'h00);
    txrdy_a = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rst_n = 1;
        t_reset; t_live_bits; t_rx_select;
        @(negedge clk); bus_addr = 5'd11;
        t_break; t_mask; t_aux; t_input_change;
        t_opcr(8'hA5); t_opcr(8'h5A);
        rts_a = 0; ctr_out = 0; txc1_a = 0; txc16_a = 0; rxc1_a = 0; rxc16_a = 0;
        txrdy_a = 0; rxrdy_a = 0; rts_b = 0; txc1_b = 0; txc16_b = 0;
        rxc1_b = 0; rxc16_b = 0; txrdy_b = 0; rxrdy_b = 0;
        t_ignored;
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule